// File: doc/BRIEF.md
# Interrupt Status and Cause Register Unit

This block holds the two control words that a processor core consults when it takes interrupts and exceptions. The status word holds a per-level interrupt mask and a three-level stack of mode/enable pairs. The cause word holds the latched pending interrupt bits and the code of the most recent exception. Its output is one interrupt request. That request is raised when interrupts are enabled at the current level and some pending bit is unmasked.

The core drives one-cycle strobes. An exception strobe with its code pushes the mode stack and enters kernel mode with interrupts disabled. A return strobe pops the stack. Software reads and writes either word through a plain select/write port, and the read data is combinational. No data streams through the block, so every pin is a plain level or strobe with no valid/ready handshake and no back-pressure. Each hardware line is sampled on every clock and latched. A pending bit stays set until software clears it.

Top module: `isr_ctrl_regs`

## Requirements
- R1: After reset, both words read 0x0000 and `irq_req` is 0.
- R2: The status word has the mask in bits 15:8 and the mode stack in bits 5:0: old pair 5:4, previous pair 3:2, current pair 1:0. In each pair the upper bit is mode (0 kernel, 1 user) and the lower bit is enable (1 enabled). Bits 7:6 read 0. A software write with `sw_sel`=0 stores the mask and stack fields from the next cycle.
- R3: An exception strobe moves current to previous and previous to old, and clears the current pair to kernel/disabled, from the next cycle.
- R4: A return strobe moves old to previous and previous to current, and the old pair keeps its value.
- R5: An exception and a return in the same cycle act as an exception alone. A software status write in a cycle that has an exception or a return is ignored entirely, including the mask.
- R6: An exception strobe stores `exc_code` in cause bits 5:2 (for example 12 overflow, 9 breakpoint, 8 syscall). No other event changes that field, and software writes do not reach it.
- R7: A hardware line i that is high in a cycle sets cause bit 10+i from the next cycle. The bit stays set after the line drops, whatever the mask and enable are. Several lines high together are all recorded.
- R8: A software write with `sw_sel`=1 clears each hardware pending bit whose written bit (15:10) is 1 and leaves bits written 0 unchanged. Bits 9:8 are software pending bits and take the written value.
- R9: A hardware line that is high in the same cycle as a software clear of its bit keeps that bit set.
- R10: `irq_req` is 1 exactly when the current enable bit is 1 and some cause bit in 15:8 is set together with the same-numbered status mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 6 | Hardware interrupt lines, sampled each cycle |
| exc_valid | input | 1 | Exception entry strobe |
| exc_code | input | 4 | Exception code stored on entry |
| rfe_valid | input | 1 | Return-from-exception strobe |
| sw_wr | input | 1 | Software write strobe |
| sw_sel | input | 1 | Word select: 0 status, 1 cause |
| sw_wdata | input | 16 | Software write data |
| sw_rdata | output | 16 | Read data of the selected word |
| irq_req | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check these properties: the shape of the stack push and pop, the forced kernel/disabled pair on entry, and the capture of the exception code. They also check that an active line is always visible as pending in the next cycle, even against a clear. Pending bits must survive any cycle without a cause write, and the request must agree with the current enable and the masked pending bits. Other behaviours appear only in the bench scenarios: the unused status bits reading zero, software pending bits taking written values, a status write being dropped when it collides with an exception, and the full write/read layout of both words.

// File: rtl/isr_pkg.sv
`timescale 1ns/1ps
package isr_pkg;
  localparam int REG_W    = 16;
  localparam int PAIR_W   = 2;
  localparam int CODE_LO  = 2;
  // mode/enable pair: upper bit = user mode, lower bit = enable
  typedef logic [PAIR_W-1:0] mode_pair_t;
  localparam mode_pair_t KERNEL_OFF = 2'b00;
endpackage

// File: rtl/isr_mode_stack.sv
`timescale 1ns/1ps
module isr_mode_stack
  import isr_pkg::*;
#(
  parameter int LEVELS = 3,
  localparam int STK_W = LEVELS * PAIR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             wr_en,
  input  logic [STK_W-1:0] wr_stack,
  output logic [STK_W-1:0] stack_q
);
  mode_pair_t lvl_q [LEVELS];

  // level 0 is current, LEVELS-1 is oldest
  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    mode_pair_t from_below, from_above;
    if (g == 0) begin : g_bot
      assign from_below = KERNEL_OFF;
    end else begin : g_mid
      assign from_below = lvl_q[g-1];
    end
    if (g == LEVELS-1) begin : g_top
      assign from_above = lvl_q[g];
    end else begin : g_low
      assign from_above = lvl_q[g+1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)      lvl_q[g] <= KERNEL_OFF;
      else if (push)   lvl_q[g] <= from_below;
      else if (pop)    lvl_q[g] <= from_above;
      else if (wr_en)  lvl_q[g] <= wr_stack[g*PAIR_W +: PAIR_W];
    end

    assign stack_q[g*PAIR_W +: PAIR_W] = lvl_q[g];
  end
endmodule

// File: rtl/isr_pending_bits.sv
`timescale 1ns/1ps
module isr_pending_bits #(
  parameter int HW_LINES = 6,
  parameter int SW_LINES = 2,
  localparam int PEND_W  = HW_LINES + SW_LINES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [HW_LINES-1:0] lines,
  input  logic                wr_en,
  input  logic [HW_LINES-1:0] clr_hw,
  input  logic [SW_LINES-1:0] set_sw,
  output logic [PEND_W-1:0]   pend_q
);
  // hardware bits in the upper part, software bits in the lower part
  for (genvar i = 0; i < HW_LINES; i++) begin : g_hw
    always_ff @(posedge clk) begin
      if (!rst_n) pend_q[SW_LINES+i] <= 1'b0;
      else        pend_q[SW_LINES+i] <= lines[i] |
                                        (pend_q[SW_LINES+i] & ~(wr_en & clr_hw[i]));
    end
  end

  for (genvar j = 0; j < SW_LINES; j++) begin : g_sw
    always_ff @(posedge clk) begin
      if (!rst_n)     pend_q[j] <= 1'b0;
      else if (wr_en) pend_q[j] <= set_sw[j];
    end
  end
endmodule

// File: rtl/isr_ctrl_regs.sv
`timescale 1ns/1ps
module isr_ctrl_regs
  import isr_pkg::*;
#(
  parameter int HW_LINES = 6,
  parameter int SW_LINES = 2,
  parameter int CODE_W   = 4,
  parameter int LEVELS   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [HW_LINES-1:0] irq_lines,
  input  logic                exc_valid,
  input  logic [CODE_W-1:0]   exc_code,
  input  logic                rfe_valid,
  input  logic                sw_wr,
  input  logic                sw_sel,
  input  logic [REG_W-1:0]    sw_wdata,
  output logic [REG_W-1:0]    sw_rdata,
  output logic                irq_req
);
  localparam int MASK_W  = HW_LINES + SW_LINES;
  localparam int MASK_LO = REG_W - MASK_W;
  localparam int HW_LO   = REG_W - HW_LINES;
  localparam int STK_W   = LEVELS * PAIR_W;

  logic [MASK_W-1:0] mask_q;
  logic [CODE_W-1:0] code_q;
  logic [STK_W-1:0]  stack_q;
  logic [MASK_W-1:0] pend_q;
  logic              st_wr, cs_wr;
  logic [REG_W-1:0]  status_w, cause_w;

  assign st_wr = sw_wr & ~sw_sel & ~exc_valid & ~rfe_valid;
  assign cs_wr = sw_wr & sw_sel;

  isr_mode_stack #(.LEVELS(LEVELS)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (exc_valid),
    .pop      (rfe_valid),
    .wr_en    (st_wr),
    .wr_stack (sw_wdata[STK_W-1:0]),
    .stack_q  (stack_q)
  );

  isr_pending_bits #(.HW_LINES(HW_LINES), .SW_LINES(SW_LINES)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .lines  (irq_lines),
    .wr_en  (cs_wr),
    .clr_hw (sw_wdata[HW_LO +: HW_LINES]),
    .set_sw (sw_wdata[MASK_LO +: SW_LINES]),
    .pend_q (pend_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      code_q <= '0;
    end else begin
      if (st_wr)     mask_q <= sw_wdata[MASK_LO +: MASK_W];
      if (exc_valid) code_q <= exc_code;
    end
  end

  always_comb begin
    status_w = '0;
    status_w[MASK_LO +: MASK_W] = mask_q;
    status_w[0 +: STK_W]        = stack_q;
    cause_w  = '0;
    cause_w[MASK_LO +: MASK_W]  = pend_q;
    cause_w[CODE_LO +: CODE_W]  = code_q;
  end

  assign sw_rdata = sw_sel ? cause_w : status_w;
  assign irq_req  = stack_q[0] & (|(mask_q & pend_q));

  logic unused_wbits;
  assign unused_wbits = ^sw_wdata[MASK_LO-1:STK_W];
endmodule

// File: rtl/isr_ctrl_regs_chk.sv
`timescale 1ns/1ps
module isr_ctrl_regs_chk #(
  parameter int HW_LINES = 6,
  parameter int CODE_W   = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [HW_LINES-1:0] irq_lines,
  input logic                exc_valid,
  input logic [CODE_W-1:0]   exc_code,
  input logic                rfe_valid,
  input logic                sw_wr,
  input logic                sw_sel,
  input logic [15:0]         status,
  input logic [15:0]         cause,
  input logic                irq_req
);
  localparam int HW_LO = 16 - HW_LINES;

  p_exc_kernel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> status[1:0] == 2'b00);

  p_exc_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> status[5:2] == $past(status[3:0]));

  p_rfe_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe_valid && !exc_valid) |=>
      (status[3:0] == $past(status[5:2]) && status[5:4] == $past(status[5:4])));

  p_code_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> cause[5:2] == $past(exc_code));

  p_code_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_valid |=> $stable(cause[5:2]));

  // R9 also covered: a line wins over a same-cycle clear
  p_line_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lines != '0) |=>
      ((cause[HW_LO +: HW_LINES] & $past(irq_lines)) == $past(irq_lines)));

  p_pend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_wr && sw_sel) |=>
      ((cause[HW_LO +: HW_LINES] & $past(cause[HW_LO +: HW_LINES]))
        == $past(cause[HW_LO +: HW_LINES])));

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == (status[0] && ((status[15:8] & cause[15:8]) != 8'h00)));
endmodule

bind isr_ctrl_regs isr_ctrl_regs_chk #(.HW_LINES(HW_LINES), .CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_lines (irq_lines),
  .exc_valid (exc_valid),
  .exc_code  (exc_code),
  .rfe_valid (rfe_valid),
  .sw_wr     (sw_wr),
  .sw_sel    (sw_sel),
  .status    (status_w),
  .cause     (cause_w),
  .irq_req   (irq_req)
);

// File: tb/isr_ctrl_regs_tb.sv
`timescale 1ns/1ps
module isr_ctrl_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  irq_lines;
  logic        exc_valid;
  logic [3:0]  exc_code;
  logic        rfe_valid;
  logic        sw_wr;
  logic        sw_sel;
  logic [15:0] sw_wdata;
  logic [15:0] sw_rdata;
  logic        irq_req;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  isr_ctrl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .exc_valid(exc_valid),
    .exc_code(exc_code), .rfe_valid(rfe_valid), .sw_wr(sw_wr), .sw_sel(sw_sel),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .irq_req(irq_req)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    irq_lines = '0; exc_valid = 0; exc_code = '0; rfe_valid = 0;
    sw_wr = 0; sw_sel = 0; sw_wdata = '0;
  endtask

  task automatic rd(input logic sel, output logic [15:0] v);
    sw_sel = sel;
    #1 v = sw_rdata;
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    sw_wr = 1; sw_sel = sel; sw_wdata = d;
    step();
    sw_wr = 0; sw_wdata = '0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    step(); step();
    rst_n = 1;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    do_reset();
    rd(0, v); chk("R1 status", v, 16'h0000);
    rd(1, v); chk("R1 cause", v, 16'h0000);
    chk("R1 irq_req", {15'd0, irq_req}, 16'h0000);
  endtask

  task automatic t_status_rw();
    logic [15:0] v;
    do_reset();
    wr(0, 16'hA5FF);
    rd(0, v); chk("R2 status layout", v, 16'hA53F);
    wr(0, 16'h5A12);
    rd(0, v); chk("R2 status rewrite", v, 16'h5A12);
  endtask

  task automatic t_exc_rfe();
    logic [15:0] v;
    do_reset();
    wr(0, 16'h001B);
    exc_valid = 1; exc_code = 4'd9;
    step(); idle();
    rd(0, v); chk("R3 push", v, 16'h002C);
    rd(1, v); chk("R6 code", v, 16'h0024);
    rfe_valid = 1;
    step(); idle();
    rd(0, v); chk("R4 pop", v, 16'h002B);
    rd(1, v); chk("R6 code kept on return", v, 16'h0024);
    rfe_valid = 1;
    step(); idle();
    rd(0, v); chk("R4 second pop old kept", v, 16'h002A);
  endtask

  task automatic t_collide();
    logic [15:0] v;
    do_reset();
    wr(0, 16'h001B);
    exc_valid = 1; exc_code = 4'd12; rfe_valid = 1;
    sw_wr = 1; sw_sel = 0; sw_wdata = 16'hFFFF;
    step(); idle();
    rd(0, v); chk("R5 exception wins, write dropped", v, 16'h002C);
    rd(1, v); chk("R6 overflow code", v, 16'h0030);
    rfe_valid = 1; sw_wr = 1; sw_sel = 0; sw_wdata = 16'hFF00;
    step(); idle();
    rd(0, v); chk("R5 write dropped on return", v, 16'h002B);
  endtask

  task automatic t_pending();
    logic [15:0] v;
    do_reset();
    irq_lines = 6'b000101;
    step(); idle();
    rd(1, v); chk("R7 two lines latched", v, 16'h1400);
    step();
    rd(1, v); chk("R7 held after line drop", v, 16'h1400);
    chk("R7 no request while disabled", {15'd0, irq_req}, 16'h0000);
    wr(1, 16'h0600);
    rd(1, v); chk("R8 clear one, set sw bit", v, 16'h1200);
    wr(1, 16'h0000);
    rd(1, v); chk("R8 zero leaves hw bit", v, 16'h1000);
    wr(1, 16'hFCFF);
    rd(1, v); chk("R6 code unwritable", v, 16'h0000);
  endtask

  task automatic t_clear_race();
    logic [15:0] v;
    do_reset();
    irq_lines = 6'b000001;
    step();
    sw_wr = 1; sw_sel = 1; sw_wdata = 16'h0400;
    step(); idle();
    rd(1, v); chk("R9 line beats clear", v, 16'h0400);
    wr(1, 16'h0400);
    rd(1, v); chk("R8 clear after line drop", v, 16'h0000);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    do_reset();
    irq_lines = 6'b000100;
    step(); idle();
    wr(0, 16'h1001);
    chk("R10 unmasked enabled", {15'd0, irq_req}, 16'h0001);
    wr(0, 16'h0801);
    chk("R10 masked off", {15'd0, irq_req}, 16'h0000);
    wr(0, 16'h1000);
    chk("R10 disabled", {15'd0, irq_req}, 16'h0000);
    wr(1, 16'h1100);
    wr(0, 16'h0101);
    chk("R10 software pending bit", {15'd0, irq_req}, 16'h0001);
    exc_valid = 1; exc_code = 4'd0;
    step(); idle();
    chk("R3 entry disables request", {15'd0, irq_req}, 16'h0000);
    rd(0, v); chk("R3 stack after entry", v, 16'h0104);
  endtask

  initial begin
    idle();
    rst_n = 0;
    @(negedge clk);
    t_reset();
    t_status_rw();
    t_exc_rfe();
    t_collide();
    t_pending();
    t_clear_race();
    t_irq();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule